// File: doc/BRIEF.md
# Banked Interrupt Enable and Routing Controller

This block handles one bank of 32 level-sensitive interrupt sources. Each raw source line is ORed with a force bit set by software, which gives the pending vector. Two separate targets each gate that vector with their own enable mask: a main processor and a coprocessor. A per-target class mask then sends every enabled pending source either to that target's normal interrupt line or to its fast interrupt line.

Software reaches the registers over a plain 32-bit bus. A write is one strobed cycle and the read data is combinational on the address. The enable and force registers change only through write-one-to-set and write-one-to-clear aliases. Software can therefore mask or unmask one source, or retrigger one source and later end its interrupt, without a read-modify-write. The class registers are loaded directly. Every enable and class register reads back exactly, so its state can be saved and restored around a power transition.

Top module: `irq_bank_ctrl`

## Requirements
- R1: A source is pending when its raw input is high or its force bit is set. The pending vector feeds both targets.
- R2: A write to offset 0x24 sets the bits of the CPU enable mask that are 1 in the write data. All other bits keep their value.
- R3: A write to offset 0x28 clears the bits of the CPU enable mask that are 1 in the write data. A write of 0xFFFFFFFF disables every CPU source in that single access.
- R4: The force register reads at 0x14. A write to 0x18 sets the 1 bits and a write to 0x1C clears them. A forced source raises the output even while its raw input is low.
- R5: The CPU class register at 0x2C is loaded directly. Class bit 0 sends the source to the IRQ line and class bit 1 sends it to the FIQ line.
- R6: The coprocessor has its own enable mask (read 0x30, set 0x34, clear 0x38) and its own class register at 0x3C. Writes to these never change the CPU outputs or the CPU registers, and CPU writes never change the coprocessor.
- R7: The CPU enable mask reads at 0x20. Reads of the enable and class registers return exactly the value last written.
- R8: A read of a set alias or a clear alias returns the current value of the register that alias modifies.
- R9: After reset every register is 0. No source is enabled or forced, all sources are in the IRQ class, and all four outputs are low.
- R10: Reads of unmapped offsets return 0, and writes to them have no effect. Writes to the read-only offsets 0x14, 0x20 and 0x30 also have no effect.
- R11: The IRQ line of a target is the OR over all sources of (pending AND enable AND class bit 0). The FIQ line is the same with class bit 1. A write takes effect on the outputs in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 32 | Raw level-sensitive interrupt sources |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| cpu_irq | output | 1 | Main processor normal interrupt |
| cpu_fiq | output | 1 | Main processor fast interrupt |
| cop_irq | output | 1 | Coprocessor normal interrupt |
| cop_fiq | output | 1 | Coprocessor fast interrupt |

## Verification
The assertions check on every cycle that:
- a set write or a clear write changes the CPU enable mask exactly as R2 and R3 require;
- clearing a force bit leaves it clear;
- a cycle without a write leaves all state untouched;
- a target with no enabled pending source keeps both its lines low;
- a class mask of all zeros never drives FIQ.

Only the bench scenarios can show the rest. These are the exact read-back values at each alias and the independence of the two targets. They also include the ignored writes to unmapped and read-only offsets, and agreement of the outputs with the bench's reference model across a long pseudo-random mix of writes and source patterns.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
    localparam int unsigned NSRC   = 32;
    localparam int unsigned ADDR_W = 8;

    // Offsets that software relies on
    localparam logic [ADDR_W-1:0] OFF_FRC      = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_FRC_SET  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_FRC_CLR  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_CEN      = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CEN_SET  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_CEN_CLR  = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_CCLS     = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_PEN      = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_PEN_SET  = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_PEN_CLR  = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_PCLS     = 8'h3C;

    localparam int unsigned NTGT = 2;

    typedef logic [NSRC-1:0] vec_t;

    typedef struct packed {
        vec_t frc;
        vec_t cpu_en;
        vec_t cpu_cls;
        vec_t cop_en;
        vec_t cop_cls;
    } bank_regs_t;
endpackage

// File: rtl/irqb_regfile.sv
module irqb_regfile
    import irqb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  vec_t              wdata,
    output bank_regs_t        regs,
    output vec_t              rdata
);
    bank_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (addr)
                OFF_FRC_SET: st_d.frc     = st_q.frc | wdata;
                OFF_FRC_CLR: st_d.frc     = st_q.frc & ~wdata;
                OFF_CEN_SET: st_d.cpu_en  = st_q.cpu_en | wdata;
                OFF_CEN_CLR: st_d.cpu_en  = st_q.cpu_en & ~wdata;
                OFF_CCLS:    st_d.cpu_cls = wdata;
                OFF_PEN_SET: st_d.cop_en  = st_q.cop_en | wdata;
                OFF_PEN_CLR: st_d.cop_en  = st_q.cop_en & ~wdata;
                OFF_PCLS:    st_d.cop_cls = wdata;
                default:     st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            OFF_FRC, OFF_FRC_SET, OFF_FRC_CLR: rdata = st_q.frc;
            OFF_CEN, OFF_CEN_SET, OFF_CEN_CLR: rdata = st_q.cpu_en;
            OFF_CCLS:                          rdata = st_q.cpu_cls;
            OFF_PEN, OFF_PEN_SET, OFF_PEN_CLR: rdata = st_q.cop_en;
            OFF_PCLS:                          rdata = st_q.cop_cls;
            default:                           rdata = '0;
        endcase
    end

    assign regs = st_q;

    AST_CEN_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFF_CEN_SET) |=> (st_q.cpu_en == ($past(st_q.cpu_en) | $past(wdata)))); // R2
    AST_CEN_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFF_CEN_CLR && wdata == '1) |=> (st_q.cpu_en == '0)); // R3
    AST_FRC_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFF_FRC_CLR) |=> ((st_q.frc & $past(wdata)) == '0)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(st_q)); // R10
endmodule

// File: rtl/irqb_route.sv
module irqb_route
    import irqb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  vec_t pend,
    input  vec_t en,
    input  vec_t cls,
    output logic irq,
    output logic fiq
);
    vec_t live;

    always_comb begin
        live = pend & en;
        irq  = |(live & ~cls);
        fiq  = |(live & cls);
    end

    AST_QUIET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend & en)) |-> (!irq && !fiq)); // R11
    AST_NO_FIQ_CLASS0: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == '0) |-> !fiq); // R5
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irqb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_lvl,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              cpu_irq,
    output logic              cpu_fiq,
    output logic              cop_irq,
    output logic              cop_fiq
);
    bank_regs_t regs;
    vec_t       pend;
    vec_t       tgt_en  [NTGT];
    vec_t       tgt_cls [NTGT];
    logic       tgt_irq [NTGT];
    logic       tgt_fiq [NTGT];

    irqb_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .regs  (regs),
        .rdata (bus_rdata)
    );

    assign pend       = src_lvl | regs.frc;
    assign tgt_en[0]  = regs.cpu_en;
    assign tgt_cls[0] = regs.cpu_cls;
    assign tgt_en[1]  = regs.cop_en;
    assign tgt_cls[1] = regs.cop_cls;

    for (genvar t = 0; t < NTGT; t++) begin : g_tgt
        irqb_route u_route (
            .clk   (clk),
            .rst_n (rst_n),
            .pend  (pend),
            .en    (tgt_en[t]),
            .cls   (tgt_cls[t]),
            .irq   (tgt_irq[t]),
            .fiq   (tgt_fiq[t])
        );
    end

    assign cpu_irq = tgt_irq[0];
    assign cpu_fiq = tgt_fiq[0];
    assign cop_irq = tgt_irq[1];
    assign cop_fiq = tgt_fiq[1];

    AST_FORCE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.frc[0] && regs.cpu_en[0] && !regs.cpu_cls[0]) |-> cpu_irq); // R1
endmodule

// File: tb/sim_irq_bank_ctrl.sv
module sim_irq_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lvl = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq, cpu_fiq, cop_irq, cop_fiq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq),
        .cop_irq(cop_irq), .cop_fiq(cop_fiq)
    );

    // Behavioural reference model
    bit [31:0] m_frc, m_cen, m_ccls, m_pen, m_pcls;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_frc <= 0; m_cen <= 0; m_ccls <= 0; m_pen <= 0; m_pcls <= 0;
        end else if (bus_wr) begin
            case (bus_addr)
                8'h18: m_frc  <= m_frc | bus_wdata;
                8'h1C: m_frc  <= m_frc & ~bus_wdata;
                8'h24: m_cen  <= m_cen | bus_wdata;
                8'h28: m_cen  <= m_cen & ~bus_wdata;
                8'h2C: m_ccls <= bus_wdata;
                8'h34: m_pen  <= m_pen | bus_wdata;
                8'h38: m_pen  <= m_pen & ~bus_wdata;
                8'h3C: m_pcls <= bus_wdata;
                default: ;
            endcase
        end
    end

    function automatic bit [31:0] m_read(input bit [7:0] a);
        if (a == 8'h14 || a == 8'h18 || a == 8'h1C) return m_frc;
        if (a == 8'h20 || a == 8'h24 || a == 8'h28) return m_cen;
        if (a == 8'h2C) return m_ccls;
        if (a == 8'h30 || a == 8'h34 || a == 8'h38) return m_pen;
        if (a == 8'h3C) return m_pcls;
        return 0;
    endfunction

    function automatic bit [3:0] m_outs();
        bit [3:0] o = 0;
        for (int i = 0; i < 32; i++) begin
            bit p = src_lvl[i] || m_frc[i];
            if (p && m_cen[i] && !m_ccls[i]) o[3] = 1;
            if (p && m_cen[i] &&  m_ccls[i]) o[2] = 1;
            if (p && m_pen[i] && !m_pcls[i]) o[1] = 1;
            if (p && m_pen[i] &&  m_pcls[i]) o[0] = 1;
        end
        return o;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R11 outputs, R7 read path)
    always @(negedge clk) begin
        if (rst_n) begin
            check("R11 outputs vs model", {28'd0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, {28'd0, m_outs()});
            check("R7 read data vs model", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(input bit [7:0] a, input bit [31:0] exp, input string tag);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        check(tag, bus_rdata, exp);
    endtask

    task automatic set_src(input bit [31:0] s);
        @(posedge clk); #2;
        src_lvl = s;
    endtask

    task automatic outs(input bit [3:0] exp, input string tag);
        @(negedge clk);
        check(tag, {28'd0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, {28'd0, exp});
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit [31:0] lf;
        bit [7:0]  offs [12];
        offs = '{8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28,
                 8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40};
        src_lvl = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R9: reset state
        outs(4'b0000, "R9 outputs low after reset");
        rd(8'h20, 0, "R9 cpu enable zero");
        rd(8'h2C, 0, "R9 cpu class zero");
        rd(8'h14, 0, "R9 force zero");
        set_src(0);
        // R2/R7/R8
        wr(8'h24, 32'h0000_00F0);
        rd(8'h20, 32'h0000_00F0, "R2 set alias sets bits R7");
        wr(8'h24, 32'h0000_0001);
        rd(8'h20, 32'h0000_00F1, "R2 other bits unchanged");
        rd(8'h24, 32'h0000_00F1, "R8 set alias reads base");
        rd(8'h28, 32'h0000_00F1, "R8 clear alias reads base");
        // R1/R11: raw source to IRQ
        set_src(32'h0000_0010);
        outs(4'b1000, "R1 raw source raises cpu irq R11");
        rd(8'h30, 0, "R6 coprocessor enable untouched");
        // R5: class routing
        wr(8'h2C, 32'h0000_0010);
        outs(4'b0100, "R5 class 1 routes to fiq");
        rd(8'h2C, 32'h0000_0010, "R7 class readback");
        wr(8'h2C, 32'h0000_0000);
        outs(4'b1000, "R5 class 0 routes to irq");
        // R3
        wr(8'h28, 32'h0000_0080);
        rd(8'h20, 32'h0000_0071, "R3 clear alias clears bits");
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h20, 0, "R3 all ones clears all");
        outs(4'b0000, "R3 outputs low after clear all");
        // R4: force
        set_src(0);
        wr(8'h24, 32'h0000_0008);
        wr(8'h18, 32'h0000_0008);
        outs(4'b1000, "R4 forced bit raises irq");
        rd(8'h14, 32'h0000_0008, "R4 force readback");
        rd(8'h1C, 32'h0000_0008, "R8 force clear alias reads base");
        wr(8'h1C, 32'h0000_0008);
        outs(4'b0000, "R4 force clear ends interrupt");
        // R6: coprocessor
        wr(8'h34, 32'hFFFF_0000);
        wr(8'h3C, 32'h8000_0000);
        set_src(32'h8000_0000);
        outs(4'b0001, "R6 cop fiq only");
        set_src(32'h0001_0000);
        outs(4'b0010, "R6 cop irq only");
        rd(8'h30, 32'hFFFF_0000, "R6 cop enable readback");
        rd(8'h3C, 32'h8000_0000, "R6 cop class readback");
        rd(8'h20, 32'h0000_0008, "R6 cpu enable unaffected");
        wr(8'h38, 32'hFFFF_FFFF);
        outs(4'b0000, "R6 cop clear all");
        // R10: unmapped and read-only offsets
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h40, 0, "R10 unmapped reads zero");
        rd(8'h20, 32'h0000_0008, "R10 write to base enable ignored");
        rd(8'h14, 0, "R10 write to base force ignored");
        rd(8'h30, 0, "R10 write to cop base ignored");
        set_src(32'hFFFF_FFFF);
        outs(4'b1000, "R10 outputs unchanged by ignored writes");
        // Pseudo-random mix, checked by the per-cycle model compare
        lf = 32'h1234_5678;
        for (int k = 0; k < 400; k++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            if (lf[3]) begin
                @(posedge clk); #2;
                src_lvl = lf & {lf[31:16], lf[15:0]} & (lf >> 7);
            end
            wr(offs[lf[27:24] % 12], lf ^ (lf << 9));
        end
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule